// File: doc/BRIEF.md
# Mains-Referenced Time-of-Day Divider Chain

This block turns a 50 Hz or 60 Hz pulse train taken from the power line into a running 24-hour time of day. All of its logic runs on one system clock. The line pulse is sampled on that clock, and each of its falling edges produces a one-cycle count event. A two-stage prescaler divides these events by 5×10 or by 6×10, depending on a rate input, and so gives one pulse per second.

After the prescaler come two identical groups, one for seconds and one for minutes. Each group has a decade units stage followed by a modulo-6 tens stage. An hours counter in BCD from 00 to 23 ends the chain. Every stage counts once on the falling edge of the top bit of the stage before it, and that top bit falls only when the earlier stage wraps. The carry therefore moves down the chain one clock per stage, like a ripple chain whose stages all share one clock.

The block also has one decode of an intermediate count, a half-minute mark. This output is qualified by the registered level of the line pulse. It can only be true in the high half of the line period, by which time the chain has settled after the last fall.

Top module: `mains_clock_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every digit output, `pps` and `half_mark` read zero in the following cycle.
- R2: The chain advances once for each high-to-low change of `line_pulse`. A low-to-high change leaves every digit unchanged.
- R3: With `rate_sel` = 0 exactly 50 line falls make one second. With `rate_sel` = 1 exactly 60 line falls make one second.
- R4: `pps` is high for exactly one clock, once per second of counted time.
- R5: `sec_units` counts 0 to 9 and returns to 0. Its return is the only thing that advances `sec_tens`.
- R6: `sec_tens` counts 0 to 5 and is forced back to 0 instead of reaching 6. The fall of its top bit (bit 2) at that moment is the only thing that advances the minutes units.
- R7: `min_units` and `min_tens` count in the same way as the seconds pair (0–9 and 0–5). The minutes units advance only in the clock after `sec_tens` has gone from 5 to 0.
- R8: The hours read 00 to 23 in BCD (`hr_tens` 0–2, `hr_units` 0–9, at most 3 when the tens read 2). They advance when the minutes go from 59 to 00, and go from 23 to 00.
- R9: Each stage updates one clock after the stage before it. After a line fall, `sec_units` has changed by the third clock while `sec_tens` still shows its old value, and the whole chain has settled within seven clocks.
- R10: `half_mark` is high only when the seconds read 30 and the line level registered at the previous clock edge was high. It is low throughout the low half of the line period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_pulse | input | 1 | Pulse derived from the power line, synchronous to `clk` |
| rate_sel | input | 1 | 0: 50 Hz line, 1: 60 Hz line |
| pps | output | 1 | One-clock strobe once per second |
| sec_units | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 3 | Seconds tens digit, 0–5 |
| min_units | output | 4 | Minutes units digit, BCD |
| min_tens | output | 3 | Minutes tens digit, 0–5 |
| hr_units | output | 4 | Hours units digit, BCD |
| hr_tens | output | 2 | Hours tens digit, 0–2 |
| half_mark | output | 1 | Half-minute decode, gated by the line level |

## Verification
The two functions that can meet in one cycle are the ripple carry and the gated half-minute decode. A carry in flight changes the digits that the decode reads, so the decode could see a count that has not yet settled. The bench drives long runs in which the count passes 30 seconds and every minute boundary. It samples the outputs twice in each line period, once late in the low half and once late in the high half. It expects `half_mark` to be clear in the low half and to match the settled seconds value in the high half. A probe taken three clocks after each fall that wraps `sec_units` expects the units digit already updated and the tens digit not yet updated, which shows the one-clock-per-stage ordering.

// File: rtl/tod_chain_pkg.sv
package tod_chain_pkg;

    // Mains frequency choice; it selects the modulus of the first prescaler stage.
    typedef enum logic {
        RATE_50HZ = 1'b0,
        RATE_60HZ = 1'b1
    } line_rate_e;

    // The first prescaler stage holds values 0..5, so three bits are enough for both rates.
    localparam int FIRST_STAGE_W = 3;

    // Hours kept as two BCD digits: tens 0..2, units 0..9.
    typedef struct packed {
        logic [1:0] tens;
        logic [3:0] units;
    } hour_bcd_t;

    // Width of a counter stage that holds the values 0..modulus-1.
    function automatic int digit_width(input int modulus);
        return (modulus < 3) ? 1 : $clog2(modulus);
    endfunction

    // Last value of the first prescaler stage before it wraps (4 gives /5, 5 gives /6).
    function automatic logic [FIRST_STAGE_W-1:0] first_stage_last(input line_rate_e rate);
        return (rate == RATE_60HZ) ? 3'd5 : 3'd4;
    endfunction

endpackage

// File: rtl/tod_line_edge.sv
module tod_line_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level_q,
    output logic fall
);

    // Line level as seen at the last clock edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
        end else begin
            level_q <= line_in;
        end
    end

    // High for one cycle when the line is low now and was high at the last edge.
    assign fall = level_q & ~line_in;

endmodule

// File: rtl/tod_ripple_stage.sv
module tod_ripple_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] last,
    output logic [W-1:0] count,
    output logic         carry
);

    localparam int TOP = W - 1;

    logic top_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            top_q <= 1'b0;
        end else begin
            top_q <= count[TOP];
            if (tick) begin
                // When the count would pass the terminal value it is forced back to zero.
                if (count >= last) begin
                    count <= '0;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // The carry is taken from the top bit alone. That bit is high through the upper
    // part of the count and falls only at the forced wrap, so no lower-bit activity reaches it.
    assign carry = top_q & ~count[TOP];

endmodule

// File: rtl/tod_hour_counter.sv
module tod_hour_counter
    import tod_chain_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    output hour_bcd_t hours
);

    hour_bcd_t hours_next;

    always_comb begin
        hours_next = hours;
        if (hours.tens == 2'd2 && hours.units == 4'd3) begin
            hours_next = '0;
        end else if (hours.units == 4'd9) begin
            hours_next.units = 4'd0;
            hours_next.tens  = hours.tens + 2'd1;
        end else begin
            hours_next.units = hours.units + 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hours <= '0;
        end else if (tick) begin
            hours <= hours_next;
        end
    end

endmodule

// File: rtl/mains_clock_chain.sv
module mains_clock_chain
    import tod_chain_pkg::*;
#(
    parameter int PRE_DECADE = 10,
    parameter int UNITS_MOD  = 10,
    parameter int TENS_MOD   = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 line_pulse,
    input  logic                                 rate_sel,
    output logic                                 pps,
    output logic [digit_width(UNITS_MOD)-1:0]    sec_units,
    output logic [digit_width(TENS_MOD)-1:0]     sec_tens,
    output logic [digit_width(UNITS_MOD)-1:0]    min_units,
    output logic [digit_width(TENS_MOD)-1:0]     min_tens,
    output logic [3:0]                           hr_units,
    output logic [1:0]                           hr_tens,
    output logic                                 half_mark
);

    localparam int PB_W    = digit_width(PRE_DECADE);
    localparam int UW      = digit_width(UNITS_MOD);
    localparam int TW      = digit_width(TENS_MOD);
    localparam int GROUPS  = 2;               // seconds, minutes
    localparam int HALF_T  = TENS_MOD / 2;    // tens value of the half-minute mark

    localparam logic [PB_W-1:0] PB_LAST   = PB_W'(PRE_DECADE - 1);
    localparam logic [UW-1:0]   UNIT_LAST = UW'(UNITS_MOD - 1);
    localparam logic [TW-1:0]   TENS_LAST = TW'(TENS_MOD - 1);
    localparam logic [TW-1:0]   HALF_TENS = TW'(HALF_T);

    // Line edge detection
    logic line_q;
    logic line_fall;

    tod_line_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_pulse),
        .level_q (line_q),
        .fall    (line_fall)
    );

    // Prescaler: /5 or /6, then /PRE_DECADE
    logic [FIRST_STAGE_W-1:0] pre_a_cnt;
    logic                     pre_a_carry;
    logic [PB_W-1:0]          pre_b_cnt;
    logic                     pre_b_carry;

    tod_ripple_stage #(.W(FIRST_STAGE_W)) u_pre_a (
        .clk   (clk),
        .rst   (rst),
        .tick  (line_fall),
        .last  (first_stage_last(line_rate_e'(rate_sel))),
        .count (pre_a_cnt),
        .carry (pre_a_carry)
    );

    tod_ripple_stage #(.W(PB_W)) u_pre_b (
        .clk   (clk),
        .rst   (rst),
        .tick  (pre_a_carry),
        .last  (PB_LAST),
        .count (pre_b_cnt),
        .carry (pre_b_carry)
    );

    // Seconds and minutes groups: units stage then tens stage
    logic [GROUPS:0]   group_tick;
    logic [UW-1:0]     unit_cnt  [GROUPS];
    logic [TW-1:0]     tens_cnt  [GROUPS];
    logic [GROUPS-1:0] unit_carry;

    assign group_tick[0] = pre_b_carry;

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        tod_ripple_stage #(.W(UW)) u_units (
            .clk   (clk),
            .rst   (rst),
            .tick  (group_tick[g]),
            .last  (UNIT_LAST),
            .count (unit_cnt[g]),
            .carry (unit_carry[g])
        );

        tod_ripple_stage #(.W(TW)) u_tens (
            .clk   (clk),
            .rst   (rst),
            .tick  (unit_carry[g]),
            .last  (TENS_LAST),
            .count (tens_cnt[g]),
            .carry (group_tick[g+1])
        );
    end

    // Hours
    hour_bcd_t hours;

    tod_hour_counter u_hours (
        .clk   (clk),
        .rst   (rst),
        .tick  (group_tick[GROUPS]),
        .hours (hours)
    );

    // Outputs
    assign pps       = pre_b_carry;
    assign sec_units = unit_cnt[0];
    assign sec_tens  = tens_cnt[0];
    assign min_units = unit_cnt[1];
    assign min_tens  = tens_cnt[1];
    assign hr_units  = hours.units;
    assign hr_tens   = hours.tens;

    // Intermediate decode: enabled only while the registered line level is high.
    // The count changes only after a fall, so by then the chain has settled.
    assign half_mark = line_q && (unit_cnt[0] == '0) && (tens_cnt[0] == HALF_TENS);

endmodule

// File: rtl/tod_chain_checker.sv
module tod_chain_checker #(
    parameter int UW  = 4,
    parameter int TW  = 3,
    parameter int SIX = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          line_pulse,
    input logic          pps,
    input logic [UW-1:0] sec_u,
    input logic [TW-1:0] sec_t,
    input logic [UW-1:0] min_u,
    input logic [3:0]    hr_u,
    input logic [1:0]    hr_t,
    input logic          half_mark
);

    localparam logic [TW:0]   TENS_LIMIT = (TW+1)'(SIX);
    localparam logic [TW-1:0] TENS_TOP   = TW'(SIX - 1);

    // R4: the seconds strobe never lasts two clocks
    p_pps_single_r4: assert property (@(posedge clk) disable iff (rst)
        pps |=> !pps);

    // R5: seconds units move only in the clock after the strobe
    p_units_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sec_u) && !$past(rst)) |-> $past(pps));

    // R6: seconds tens never reach the modulus
    p_tens_range_r6: assert property (@(posedge clk) disable iff (rst)
        {1'b0, sec_t} < TENS_LIMIT);

    // R7 and R9: minutes units move one clock after seconds tens wrapped to zero
    p_min_ripple_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(min_u) && !$past(rst) && !$past(rst, 2))
            |-> ($past(sec_t) == '0 && $past(sec_t, 2) == TENS_TOP));

    // R8: hours stay a valid 00..23 BCD value
    p_hour_range_r8: assert property (@(posedge clk) disable iff (rst)
        (hr_u <= 4'd9) && (hr_t <= 2'd2) && ((hr_t != 2'd2) || (hr_u <= 4'd3)));

    // R10: the half-minute mark needs the line high at the previous edge
    p_mark_gate_r10: assert property (@(posedge clk) disable iff (rst)
        half_mark |-> $past(line_pulse));

endmodule

bind mains_clock_chain tod_chain_checker #(
    .UW  (UW),
    .TW  (TW),
    .SIX (TENS_MOD)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_pulse (line_pulse),
    .pps        (pps),
    .sec_u      (sec_units),
    .sec_t      (sec_tens),
    .min_u      (min_units),
    .hr_u       (hr_units),
    .hr_t       (hr_tens),
    .half_mark  (half_mark)
);

// File: tb/mains_clock_chain_tb.sv
module mains_clock_chain_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_pulse = 1'b1;
    logic rate_sel = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Default instance
    logic       pps, half_mark;
    logic [3:0] sec_units, min_units, hr_units;
    logic [2:0] sec_tens, min_tens;
    logic [1:0] hr_tens;

    mains_clock_chain u_dut (
        .clk(clk), .rst(rst), .line_pulse(line_pulse), .rate_sel(rate_sel),
        .pps(pps), .sec_units(sec_units), .sec_tens(sec_tens),
        .min_units(min_units), .min_tens(min_tens),
        .hr_units(hr_units), .hr_tens(hr_tens), .half_mark(half_mark)
    );

    // Shortened instance (/2 stages) so that a full day fits in the run
    logic       f_pps, f_mark;
    logic [0:0] f_su, f_st, f_mu, f_mt;
    logic [3:0] f_hu;
    logic [1:0] f_ht;

    mains_clock_chain #(.PRE_DECADE(2), .UNITS_MOD(2), .TENS_MOD(2)) u_fast (
        .clk(clk), .rst(rst), .line_pulse(line_pulse), .rate_sel(rate_sel),
        .pps(f_pps), .sec_units(f_su), .sec_tens(f_st),
        .min_units(f_mu), .min_tens(f_mt),
        .hr_units(f_hu), .hr_tens(f_ht), .half_mark(f_mark)
    );

    typedef struct {
        int su, st, mu, mt, hu, ht, mark;
        int fsu, fst, fmu, fmt, fhu, fht;
        bit high;
    } exp_t;

    exp_t sb_q[$];
    event sample_ev;
    int   checks = 0;
    int   errors = 0;
    int   falls  = 0;
    int   pps_seen = 0;
    bit   done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (falls=%0d)", req, act, exp, falls);
        end
    endtask

    function automatic int pre_div(input int full);
        int a;
        a = rate_sel ? 6 : 5;
        return full ? a * 10 : a * 2;
    endfunction

    // Reference time from the number of line falls since reset
    function automatic exp_t model(input int n, input bit high);
        exp_t e;
        int s, sf, h, hf;
        s  = n / pre_div(1);
        h  = (s / 3600) % 24;
        e.su = s % 10;        e.st = (s / 10) % 6;
        e.mu = (s / 60) % 10; e.mt = (s / 600) % 6;
        e.hu = h % 10;        e.ht = h / 10;
        e.mark = (high && (s % 60) == 30) ? 1 : 0;
        sf = n / pre_div(0);
        hf = (sf / 16) % 24;
        e.fsu = sf % 2;       e.fst = (sf / 2) % 2;
        e.fmu = (sf / 4) % 2; e.fmt = (sf / 8) % 2;
        e.fhu = hf % 10;      e.fht = hf / 10;
        e.high = high;
        return e;
    endfunction

    // Monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.high) begin
                    // R2: the rising line edge must not move any digit
                    chk("R2 sec_units", int'(sec_units), e.su);
                    chk("R2 sec_tens", int'(sec_tens), e.st);
                    chk("R2 min_units", int'(min_units), e.mu);
                    chk("R2 hours", int'(hr_tens) * 10 + int'(hr_units), e.ht * 10 + e.hu);
                end else begin
                    chk("R5 sec_units", int'(sec_units), e.su);
                    chk("R6 sec_tens", int'(sec_tens), e.st);
                    chk("R7 min_units", int'(min_units), e.mu);
                    chk("R7 min_tens", int'(min_tens), e.mt);
                    chk("R8 hr_units", int'(hr_units), e.hu);
                    chk("R8 hr_tens", int'(hr_tens), e.ht);
                end
                // R10: mark low in the low half, set at 30 s in the high half
                chk("R10 half_mark", int'(half_mark), e.mark);
                chk("R8 fast seconds", int'(f_st) * 2 + int'(f_su), e.fst * 2 + e.fsu);
                chk("R8 fast minutes", int'(f_mt) * 2 + int'(f_mu), e.fmt * 2 + e.fmu);
                chk("R8 fast hours", int'(f_ht) * 10 + int'(f_hu), e.fht * 10 + e.fhu);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && pps) pps_seen++;
    end

    // Driver: one full line period, 8 clocks low then 4 high
    task automatic line_period();
        int s_old, s_new;
        s_old = falls / pre_div(1);
        line_pulse = 1'b0;
        falls++;
        s_new = falls / pre_div(1);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 3 && s_new != s_old && (s_new % 10) == 0) begin
                // R9: units already wrapped, tens still shows the old value
                chk("R9 units early", int'(sec_units), 0);
                chk("R9 tens late", int'(sec_tens), (s_old / 10) % 6);
            end
        end
        sb_q.push_back(model(falls, 1'b0));
        ->sample_ev;
        line_pulse = 1'b1;
        for (int k = 1; k <= 4; k++) @(negedge clk);
        sb_q.push_back(model(falls, 1'b1));
        ->sample_ev;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit rate);
        @(negedge clk);
        rst = 1'b1;
        rate_sel = rate;
        line_pulse = 1'b1;
        repeat (3) @(negedge clk);
        // R1: all outputs cleared while reset is held
        chk("R1 sec", int'(sec_tens) * 10 + int'(sec_units), 0);
        chk("R1 min", int'(min_tens) * 10 + int'(min_units), 0);
        chk("R1 hours", int'(hr_tens) * 10 + int'(hr_units), 0);
        chk("R1 pps", int'(pps), 0);
        chk("R1 half_mark", int'(half_mark), 0);
        chk("R1 fast", int'(f_ht) + int'(f_hu) + int'(f_mt) + int'(f_su), 0);
        rst = 1'b0;
        falls = 0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int base;
        // 50 Hz run: 78 s on the main chain, past 24 h on the shortened chain
        do_reset(1'b0);
        base = pps_seen;
        for (int i = 0; i < 3900; i++) line_period();
        chk("R3 R4 pps count at 50 Hz", pps_seen - base, 78);

        // R1: reset from a non-zero state
        do_reset(1'b1);

        // 60 Hz run: the seventh second arrives on fall 420, not 419
        base = pps_seen;
        for (int i = 0; i < 419; i++) line_period();
        chk("R3 pps count after 419 falls", pps_seen - base, 6);
        chk("R3 sec_units after 419 falls", int'(sec_units), 6);
        line_period();
        chk("R3 pps count after 420 falls", pps_seen - base, 7);
        chk("R3 sec_units after 420 falls", int'(sec_units), 7);

        done = 1'b1;
        @(negedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2: actual=hung expected=finished");
            summary();
        end
    end

endmodule